// File: doc/BRIEF.md
# Truncating Carry-Save Tree Multiplier

This block is a purely combinational unsigned multiplier whose product is as wide as its operands. Only the low `WIDTH` bits of the product exist: any contribution at weight `WIDTH` or above is never formed. That makes it suitable for address scaling, hashing and modular arithmetic, where the upper half of a double-width product would be thrown away anyway.

The operands feed a triangular array of AND terms. Row `i` takes operand `a` shifted left by `i` and gated by `b[i]`, and only the columns below `WIDTH` are kept. Layers of full-adder cells compress three rows into two at a time until two addends remain. A single carry-propagate adder then sums those two addends modulo 2^WIDTH. The number of compression layers is worked out from `WIDTH` at elaboration, so any width from 1 to 32 builds from the same source.

Top module: `tmul_wallace`

## Requirements
- R1: For any operands, `p_o` equals `(a_i * b_i) mod 2^WIDTH`, treating both operands as unsigned.
- R2: When `b_i` has exactly one bit set, at position k, `p_o` equals `a_i` shifted left by k with the bits shifted past position WIDTH-1 lost.
- R3: When either operand is zero, `p_o` is zero.
- R4: When either operand equals 1, `p_o` equals the other operand.
- R5: When both operands are all ones, `p_o` equals 1.
- R6: When `a_i` has only its top bit (WIDTH-1) set and `b_i[0]` is 0, `p_o` is zero, because every carry beyond the top column is discarded.
- R7: With WIDTH = 1, `p_o` equals `a_i & b_i`; at every width, bit 0 of `p_o` equals `a_i[0] & b_i[0]`.
- R8: The same source gives correct products at WIDTH values of 1, 3, 8, 16 and 32, including the widths that need no compression layer at all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Multiplicand, unsigned |
| b_i | input | WIDTH | Multiplier, unsigned |
| p_o | output | WIDTH | Low WIDTH bits of the product |

## Verification
The hardest case to reach from the ports is a carry that ripples all the way into the top column, or one that should fall off past it. Random operands rarely put a long chain of ones into the same column of both addends. The stimulus therefore includes all-ones operands, where every column is full and the true product wraps to 1. It also includes a top-bit-only multiplicand times even multipliers, where every contribution lands at or above weight WIDTH and must vanish. Single-bit multipliers walked across every position give each row of the array in isolation, at several widths.

// File: rtl/tmul_pkg.sv
package tmul_pkg;

  // Rows left after one compression layer: each group of three becomes two,
  // a remainder of one or two rows is passed on untouched.
  function automatic int rows_next(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  // Rows present at the input of layer lv, starting from n rows.
  function automatic int rows_at(input int n, input int lv);
    int r;
    r = n;
    for (int k = 0; k < lv; k++) r = rows_next(r);
    return r;
  endfunction

  // Number of layers needed to get down to two rows or fewer.
  function automatic int level_count(input int n);
    int r;
    int c;
    r = n;
    c = 0;
    while (r > 2) begin
      r = rows_next(r);
      c++;
    end
    return c;
  endfunction

  // One full-adder cell.
  function automatic logic fa_sum(input logic x, input logic y, input logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic z);
    return (x & y) | (y & z) | (x & z);
  endfunction

endpackage

// File: rtl/tmul_pp_array.sv
module tmul_pp_array #(
  parameter int W = 16
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W*W-1:0] rows_o
);

  // Term of row r at column c: zero below the row's offset, otherwise
  // the operand bit that lands in this column.
  function automatic logic pp_bit(input logic [W-1:0] a, input logic b, input int c, input int r);
    if (c < r) return 1'b0;
    return a[c-r] & b;
  endfunction

  for (genvar r = 0; r < W; r++) begin : g_row
    for (genvar c = 0; c < W; c++) begin : g_col
      assign rows_o[r*W + c] = pp_bit(a_i, b_i[r], c, r);
    end
  end

endmodule

// File: rtl/tmul_csa_level.sv
module tmul_csa_level #(
  parameter int W    = 16,
  parameter int N_IN = 3,
  localparam int NG    = N_IN / 3,
  localparam int NP    = N_IN % 3,
  localparam int N_OUT = 2 * NG + NP
) (
  input  logic [N_IN*W-1:0]  rows_i,
  output logic [N_OUT*W-1:0] rows_o
);
  import tmul_pkg::*;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int X0 = (3*g)     * W;
    localparam int Y0 = (3*g + 1) * W;
    localparam int Z0 = (3*g + 2) * W;
    localparam int S0 = (2*g)     * W;
    localparam int C0 = (2*g + 1) * W;

    for (genvar c = 0; c < W; c++) begin : g_sum
      assign rows_o[S0 + c] = fa_sum(rows_i[X0 + c], rows_i[Y0 + c], rows_i[Z0 + c]);
    end

    assign rows_o[C0] = 1'b0;
    // Carry out of column c goes to column c+1; the top column's carry is dropped.
    for (genvar c = 1; c < W; c++) begin : g_cry
      assign rows_o[C0 + c] = fa_carry(rows_i[X0 + c - 1], rows_i[Y0 + c - 1], rows_i[Z0 + c - 1]);
    end
  end

  for (genvar k = 0; k < NP; k++) begin : g_pass
    assign rows_o[(2*NG + k)*W +: W] = rows_i[(3*NG + k)*W +: W];
  end

endmodule

// File: rtl/tmul_cpa.sv
module tmul_cpa #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] s_o
);

  // Ripple sum modulo 2^W; the final carry out is never produced.
  function automatic logic [W-1:0] add_mod(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] s;
    logic         cy;
    cy = 1'b0;
    for (int c = 0; c < W; c++) begin
      s[c] = x[c] ^ y[c] ^ cy;
      cy   = (x[c] & y[c]) | (cy & (x[c] ^ y[c]));
    end
    return s;
  endfunction

  assign s_o = add_mod(x_i, y_i);

endmodule

// File: rtl/tmul_wallace.sv
module tmul_wallace #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] p_o
);
  import tmul_pkg::*;

  localparam int NLEV = level_count(WIDTH);
  localparam int FR   = rows_at(WIDTH, NLEV);

  // Named internal nets, observed by the bound checker.
  logic [WIDTH*WIDTH-1:0] pp_bus;
  logic [FR*WIDTH-1:0]    final_bus;
  logic [WIDTH-1:0]       addend_x;
  logic [WIDTH-1:0]       addend_y;

  tmul_pp_array #(.W(WIDTH)) pp_i (
    .a_i    (a_i),
    .b_i    (b_i),
    .rows_o (pp_bus)
  );

  for (genvar lv = 0; lv < NLEV; lv++) begin : g_lvl
    localparam int RIN  = rows_at(WIDTH, lv);
    localparam int ROUT = rows_next(RIN);
    logic [RIN*WIDTH-1:0]  rin;
    logic [ROUT*WIDTH-1:0] rout;

    if (lv == 0) begin : g_first
      assign rin = pp_bus;
    end else begin : g_chain
      assign rin = g_lvl[lv-1].rout;
    end

    tmul_csa_level #(.W(WIDTH), .N_IN(RIN)) csa_i (
      .rows_i (rin),
      .rows_o (rout)
    );
  end

  if (NLEV == 0) begin : g_nolvl
    assign final_bus = pp_bus;
  end else begin : g_haslvl
    assign final_bus = g_lvl[NLEV-1].rout;
  end

  assign addend_x = final_bus[WIDTH-1:0];
  if (FR == 2) begin : g_two
    assign addend_y = final_bus[2*WIDTH-1:WIDTH];
  end else begin : g_one
    assign addend_y = '0;
  end

  tmul_cpa #(.W(WIDTH)) cpa_i (
    .x_i (addend_x),
    .y_i (addend_y),
    .s_o (p_o)
  );

endmodule

// File: rtl/tmul_wallace_chk.sv
module tmul_wallace_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] p_o,
  input logic [W-1:0] addend_x,
  input logic [W-1:0] addend_y
);

  localparam logic [W-1:0] ONE      = W'(1);
  localparam logic [W-1:0] TOP_ONLY = W'(1) << (W - 1);

  logic [W-1:0] ref_p;
  logic [W-1:0] tree_sum;

  always_comb begin
    ref_p    = a_i * b_i;
    tree_sum = addend_x + addend_y;
    if (!$isunknown({a_i, b_i, p_o, addend_x, addend_y})) begin
      // R1: the two tree outputs still carry the truncated product
      assert_tree_value_R1: assert (tree_sum == ref_p)
        else $error("tree addends do not sum to the product");
      // R1: the final adder output matches the tree outputs
      assert_cpa_sum_R1: assert (p_o == tree_sum)
        else $error("final adder disagrees with addends");
      assert_zero_R3: assert (!((a_i == '0) || (b_i == '0)) || (p_o == '0))
        else $error("zero operand gave nonzero product");
      assert_unit_R4: assert (!(b_i == ONE) || (p_o == a_i))
        else $error("multiply by one altered operand");
      assert_ones_R5: assert (!((a_i == '1) && (b_i == '1)) || (p_o == ONE))
        else $error("all-ones product is not 1");
      assert_drop_R6: assert (!((a_i == TOP_ONLY) && !b_i[0]) || (p_o == '0))
        else $error("carry past top column leaked");
      assert_lsb_R7: assert (p_o[0] == (a_i[0] & b_i[0]))
        else $error("product bit 0 wrong");
      for (int k = 0; k < W; k++) begin
        if (b_i == (ONE << k)) begin
          assert_shift_R2: assert (p_o == (a_i << k))
            else $error("single-bit multiplier not a shift");
        end
      end
    end
  end

endmodule

bind tmul_wallace tmul_wallace_chk #(.W(WIDTH)) chk_i (
  .a_i      (a_i),
  .b_i      (b_i),
  .p_o      (p_o),
  .addend_x (addend_x),
  .addend_y (addend_y)
);

// File: tb/tmul_wallace_tb_top.sv
`timescale 1ns/1ps
module tmul_wallace_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Five instances of different width; index 3 is the main one.
  logic [0:0]  a1, b1, p1;
  logic [2:0]  a3, b3, p3;
  logic [7:0]  a8, b8, p8;
  logic [15:0] a16, b16, p16;
  logic [31:0] a32, b32, p32;

  tmul_wallace #(.WIDTH(1))  u_w1  (.a_i(a1),  .b_i(b1),  .p_o(p1));
  tmul_wallace #(.WIDTH(3))  u_w3  (.a_i(a3),  .b_i(b3),  .p_o(p3));
  tmul_wallace #(.WIDTH(8))  u_w8  (.a_i(a8),  .b_i(b8),  .p_o(p8));
  tmul_wallace #(.WIDTH(16)) dut_i (.a_i(a16), .b_i(b16), .p_o(p16));
  tmul_wallace #(.WIDTH(32)) u_w32 (.a_i(a32), .b_i(b32), .p_o(p32));

  function automatic int wid(input int sel);
    case (sel)
      0: return 1;
      1: return 3;
      2: return 8;
      3: return 16;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] mask_of(input int w);
    if (w >= 32) return 32'hFFFF_FFFF;
    return (32'd1 << w) - 32'd1;
  endfunction

  function automatic logic [31:0] got_of(input int sel);
    case (sel)
      0: return {31'd0, p1};
      1: return {29'd0, p3};
      2: return {24'd0, p8};
      3: return {16'd0, p16};
      default: return p32;
    endcase
  endfunction

  // Driver: applies operands at the falling edge and queues the expected value.
  task automatic drive(input int sel, input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [31:0] m;
    logic [63:0] full;
    item_t it;
    m = mask_of(wid(sel));
    @(negedge clk);
    a1 = a[0:0];  b1 = b[0:0];
    a3 = a[2:0];  b3 = b[2:0];
    a8 = a[7:0];  b8 = b[7:0];
    a16 = a[15:0]; b16 = b[15:0];
    a32 = a;      b32 = b;
    full   = {32'd0, a & m} * {32'd0, b & m};
    it.sel = sel;
    it.exp = full[31:0] & m;
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: compares at the next rising edge, half a cycle after the drive.
  initial begin
    forever begin
      @(posedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it  = q.pop_front();
        got = got_of(it.sel) & mask_of(wid(it.sel));
        n_cmp++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s (width %0d): actual %0h expected %0h", it.tag, wid(it.sel), got, it.exp);
        end
      end
    end
  end

  initial begin
    a1 = '0; b1 = '0; a3 = '0; b3 = '0; a8 = '0; b8 = '0;
    a16 = '0; b16 = '0; a32 = '0; b32 = '0;

    // R7: one-bit instance, all four combinations
    for (int v = 0; v < 4; v++) drive(0, 32'(v & 1), 32'(v >> 1), "R7 one-bit");

    for (int s = 1; s < 5; s++) begin
      logic [31:0] m;
      int w;
      w = wid(s);
      m = mask_of(w);
      drive(s, 32'h0, 32'h0, "R3 zero both");
      drive(s, 32'h0, m, "R3 zero a");
      drive(s, m, 32'h0, "R3 zero b");
      drive(s, 32'h1, m & 32'h5A5A_5A5A, "R4 one a");
      drive(s, m & 32'hA5C3_3C5A, 32'h1, "R4 one b");
      drive(s, m, m, "R5 all ones");
      drive(s, 32'd1 << (w - 1), 32'h2, "R6 top bit times two");
      drive(s, 32'd1 << (w - 1), m & 32'hFFFF_FFFE, "R6 top bit times even");
      for (int k = 0; k < w; k++) drive(s, m & 32'hDEAD_BEEF, 32'd1 << k, "R2 single-bit multiplier");
      for (int k = 0; k < w; k++) drive(s, m, 32'd1 << k, "R2 ones shifted");
      drive(s, m, 32'h3, "R1 ones times three");
      drive(s, m >> 1, m >> 1, "R1 half ones squared");
      for (int r = 0; r < 40; r++) drive(s, $urandom, $urandom, "R1 R8 random");
      for (int r = 0; r < 10; r++) drive(s, $urandom | 32'h8000_0001, $urandom | 32'h8000_0001, "R8 dense random");
    end

    @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

endmodule